// File: doc/BRIEF.md
# Three-Button Mouse Packet Encoder

This block turns one pointer event into a five-byte report for a serial mouse link and hands the bytes to a downstream byte queue. An event is a one-cycle strobe that carries a signed 16-bit horizontal delta, a signed 16-bit vertical delta and the state of the left, middle and right buttons.

The first byte is a sync/button byte with active-low button flags. The second byte is the horizontal motion and the third is the vertical motion with its sign flipped. Both motion values are clamped so that they fit in a signed byte. Two zero bytes end the report.

The bytes leave over a valid/ready handshake, one byte for each accepted transfer. An event that arrives while a report is still being sent waits in a one-deep holding slot and is sent once that report is finished.

Top module: `mouse_pkt_encoder`

## Requirements
- R1: After reset `out_valid` is low and stays low until an event is strobed.
- R2: Byte 0 is 0x87 with bit 2 cleared when `btn_left` is 1, bit 1 cleared when `btn_mid` is 1, and bit 0 cleared when `btn_right` is 1. Bits 7..3 are always 10000.
- R3: Byte 1 is `delta_x` clamped to -127..+127 and sent as an 8-bit two's-complement value, so 0x80 never appears.
- R4: Byte 2 is the negation of `delta_y`, computed without overflow and then clamped to -127..+127 in two's complement. `delta_y` = -32768 gives 0x7F.
- R5: Bytes 3 and 4 are always 0x00.
- R6: The bytes leave in the order 0 to 4, and each one advances only on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R7: An event strobed while a report is in progress is held and sent right after the last byte of that report. If several events arrive while one is already held, only the most recent one is kept. After the held report, no further bytes appear.
- R8: From idle, byte 0 becomes valid in the second cycle after the strobe: one register stage for the holding slot and one for the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_stb | input | 1 | One-cycle event strobe |
| delta_x | input | 16 | Signed horizontal motion |
| delta_y | input | 16 | Signed vertical motion |
| btn_left | input | 1 | Left button pressed when 1 |
| btn_mid | input | 1 | Middle button pressed when 1 |
| btn_right | input | 1 | Right button pressed when 1 |
| out_data | output | 8 | Current report byte |
| out_valid | output | 1 | `out_data` holds a byte to send |
| out_ready | input | 1 | Downstream accepts the byte this cycle |

## Verification
Some properties are checked by assertions on every cycle:
- a stalled byte stays put;
- the fixed top bits of the sync byte;
- the zero padding bytes;
- motion bytes never carry 0x80;
- a held event is taken as soon as the serializer is free.

Other behaviour can only be shown by the bench's directed scenarios:
- the exact button-to-bit mapping;
- clamping at both ends;
- the sign flip on the vertical axis, including the most negative input;
- the two-cycle start latency;
- that a newer held event replaces an older one and that nothing extra follows.

// File: rtl/mpe_pkg.sv
package mpe_pkg;

    localparam int DELTA_W  = 16;
    localparam int PKT_LEN  = 5;
    localparam int MOT_LIM  = 127;
    localparam logic [7:0] SYNC_IDLE = 8'h87;

    typedef struct packed {
        logic signed [DELTA_W-1:0] dx;
        logic signed [DELTA_W-1:0] dy;
        logic                      left;
        logic                      mid;
        logic                      right;
    } mouse_evt_t;

    typedef logic [PKT_LEN-1:0][7:0] mouse_pkt_t;

    // Clamp a widened signed value into a symmetric signed byte.
    function automatic logic [7:0] clamp_byte(input logic signed [DELTA_W:0] v);
        logic signed [DELTA_W:0] hi;
        logic signed [DELTA_W:0] lo;
        hi = (DELTA_W+1)'(MOT_LIM);
        lo = -hi;
        if (v > hi)      return 8'(MOT_LIM);
        else if (v < lo) return 8'(-MOT_LIM);
        else             return v[7:0];
    endfunction

    function automatic logic [7:0] sync_byte(input mouse_evt_t e);
        return SYNC_IDLE ^ {5'b0, e.left, e.mid, e.right};
    endfunction

endpackage

// File: rtl/mpe_event_slot.sv
module mpe_event_slot
    import mpe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stb,
    input  mouse_evt_t evt_in,
    input  logic       take,
    output logic       held,
    output mouse_evt_t evt_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= 1'b0;
            evt_out <= '0;
        end else if (stb) begin
            held    <= 1'b1;
            evt_out <= evt_in;
        end else if (take) begin
            held    <= 1'b0;
        end
    end

    // R7: a taken event leaves the slot unless a new one arrives
    a_r7_take_clears: assert property (@(posedge clk) disable iff (rst)
        (take && !stb) |=> !held);

    // R7: a strobe always leaves an event held
    a_r7_stb_holds: assert property (@(posedge clk) disable iff (rst)
        stb |=> held);

endmodule

// File: rtl/mpe_packet_build.sv
module mpe_packet_build
    import mpe_pkg::*;
(
    input  mouse_evt_t evt,
    output mouse_pkt_t pkt
);

    logic signed [DELTA_W:0] wide_x;
    logic signed [DELTA_W:0] wide_ny;

    always_comb begin
        wide_x  = {evt.dx[DELTA_W-1], evt.dx};
        wide_ny = -{evt.dy[DELTA_W-1], evt.dy};
    end

    assign pkt[0] = sync_byte(evt);
    assign pkt[1] = clamp_byte(wide_x);
    assign pkt[2] = clamp_byte(wide_ny);

    genvar g;
    generate
        for (g = 3; g < PKT_LEN; g++) begin : g_pad
            assign pkt[g] = 8'h00;
        end
    endgenerate

endmodule

// File: rtl/mpe_byte_serializer.sv
module mpe_byte_serializer
    import mpe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       held,
    input  mouse_pkt_t next_pkt,
    output logic       take,
    output logic [7:0] out_data,
    input  logic       out_ready,
    output logic       out_valid
);

    localparam int IDX_W = $clog2(PKT_LEN);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);

    logic             busy;
    logic [IDX_W-1:0] idx;
    mouse_pkt_t       pkt_q;
    logic             xfer;
    logic             at_end;

    always_comb begin
        xfer   = busy && out_ready;
        at_end = xfer && (idx == LAST);
        take   = held && (!busy || at_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx   <= '0;
            pkt_q <= '0;
        end else if (take) begin
            busy  <= 1'b1;
            idx   <= '0;
            pkt_q <= next_pkt;
        end else if (at_end) begin
            busy  <= 1'b0;
            idx   <= '0;
        end else if (xfer) begin
            idx   <= idx + 1'b1;
        end
    end

    assign out_valid = busy;
    assign out_data  = pkt_q[idx];

    // R6: a stalled byte stays valid and unchanged
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R2: fixed top bits of the sync byte
    a_r2_sync_top: assert property (@(posedge clk) disable iff (rst)
        (out_valid && idx == '0) |-> (out_data[7:3] == 5'b10000));

    // R5: padding bytes are zero
    a_r5_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && idx >= IDX_W'(3)) |-> (out_data == 8'h00));

    // R3 and R4: a clamped motion byte never holds the asymmetric extreme
    a_r3_motion_range: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (idx == IDX_W'(1) || idx == IDX_W'(2))) |-> (out_data != 8'h80));

    // R7: a held event starts as soon as the serializer is free
    a_r7_start_when_free: assert property (@(posedge clk) disable iff (rst)
        (held && !busy) |=> (busy && idx == '0));

endmodule

// File: rtl/mouse_pkt_encoder.sv
module mouse_pkt_encoder
    import mpe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        evt_stb,
    input  logic [15:0] delta_x,
    input  logic [15:0] delta_y,
    input  logic        btn_left,
    input  logic        btn_mid,
    input  logic        btn_right,
    output logic [7:0]  out_data,
    output logic        out_valid,
    input  logic        out_ready
);

    mouse_evt_t evt_in;
    mouse_evt_t evt_held;
    mouse_pkt_t pkt_next;
    logic       held;
    logic       take;

    always_comb begin
        evt_in.dx    = delta_x;
        evt_in.dy    = delta_y;
        evt_in.left  = btn_left;
        evt_in.mid   = btn_mid;
        evt_in.right = btn_right;
    end

    mpe_event_slot u_slot (
        .clk     (clk),
        .rst     (rst),
        .stb     (evt_stb),
        .evt_in  (evt_in),
        .take    (take),
        .held    (held),
        .evt_out (evt_held)
    );

    mpe_packet_build u_build (
        .evt (evt_held),
        .pkt (pkt_next)
    );

    mpe_byte_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .held      (held),
        .next_pkt  (pkt_next),
        .take      (take),
        .out_data  (out_data),
        .out_ready (out_ready),
        .out_valid (out_valid)
    );

    // R1: no output in the cycle right after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

// File: tb/mouse_pkt_encoder_tb.sv
module mouse_pkt_encoder_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        evt_stb;
    logic [15:0] delta_x;
    logic [15:0] delta_y;
    logic        btn_left, btn_mid, btn_right;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mouse_pkt_encoder dut_i (
        .clk(clk), .rst(rst), .evt_stb(evt_stb),
        .delta_x(delta_x), .delta_y(delta_y),
        .btn_left(btn_left), .btn_mid(btn_mid), .btn_right(btn_right),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    function automatic logic [7:0] sat(input int v);
        if (v > 127)  return 8'd127;
        if (v < -127) return 8'h81;
        return 8'(v);
    endfunction

    function automatic logic [39:0] expect_pkt(input int dx, input int dy,
                                               input bit l, input bit m, input bit r);
        logic [7:0] b0;
        b0 = 8'h87;
        if (l) b0[2] = 1'b0;
        if (m) b0[1] = 1'b0;
        if (r) b0[0] = 1'b0;
        return {8'h00, 8'h00, sat(-dy), sat(dx), b0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input int dx, input int dy, input bit l, input bit m, input bit r);
        evt_stb = 1'b1;
        delta_x = 16'(dx);
        delta_y = 16'(dy);
        btn_left = l; btn_mid = m; btn_right = r;
        @(negedge clk);
        evt_stb = 1'b0;
    endtask

    // Receive five bytes; the stall option holds ready low for one cycle per byte.
    task automatic get_packet(input logic [39:0] exp, input bit stall, input string req);
        for (int i = 0; i < 5; i++) begin
            int w = 0;
            logic [7:0] first;
            while (!out_valid && w < 50) begin
                @(negedge clk);
                w++;
            end
            check(out_valid, {req, " R6 byte valid"}, out_valid, 1);
            if (stall) begin
                first = out_data;
                out_ready = 1'b0;
                @(negedge clk);
                check(out_valid && out_data == first, "R6 stall hold", out_data, first);
            end
            check(out_data == exp[i*8 +: 8], req, out_data, exp[i*8 +: 8]);
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
    endtask

    task automatic expect_idle(input int cycles, input string req);
        bit seen = 0;
        for (int i = 0; i < cycles; i++) begin
            if (out_valid) seen = 1;
            @(negedge clk);
        end
        check(!seen, req, seen, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset idle", out_valid, 0);
        expect_idle(5, "R1 idle before event");
    endtask

    task automatic t_latency;
        strobe(3, 4, 0, 0, 0);
        check(!out_valid, "R8 not valid after one edge", out_valid, 0);
        @(negedge clk);
        check(out_valid, "R8 valid after two edges", out_valid, 1);
        get_packet(expect_pkt(3, 4, 0, 0, 0), 0, "R8 packet");
    endtask

    task automatic t_buttons;
        for (int c = 0; c < 8; c++) begin
            strobe(0, 0, c[2], c[1], c[0]);
            get_packet(expect_pkt(0, 0, c[2], c[1], c[0]), 0, "R2 buttons");
        end
    endtask

    task automatic t_motion;
        strobe(127, -127, 1, 0, 0);
        get_packet(expect_pkt(127, -127, 1, 0, 0), 0, "R3 R4 edge in range");
        strobe(300, 200, 0, 0, 0);
        get_packet(expect_pkt(300, 200, 0, 0, 0), 0, "R3 R4 clamp");
        strobe(-32768, -32768, 0, 1, 0);
        get_packet(expect_pkt(-32768, -32768, 0, 1, 0), 0, "R3 R4 most negative");
        strobe(-128, 128, 0, 0, 1);
        get_packet(expect_pkt(-128, 128, 0, 0, 1), 0, "R3 R4 just outside");
        strobe(-5, -9, 0, 0, 0);
        get_packet(expect_pkt(-5, -9, 0, 0, 0), 0, "R3 R4 R5 small");
    endtask

    task automatic t_stall;
        strobe(40, -60, 1, 1, 1);
        get_packet(expect_pkt(40, -60, 1, 1, 1), 1, "R6 stalled order");
    endtask

    task automatic t_queued;
        strobe(10, 10, 0, 0, 0);
        @(negedge clk);
        strobe(20, 20, 1, 0, 0);
        strobe(-1000, 7, 0, 1, 1);
        get_packet(expect_pkt(10, 10, 0, 0, 0), 0, "R7 first report");
        get_packet(expect_pkt(-1000, 7, 0, 1, 1), 0, "R7 latest held report");
        expect_idle(10, "R7 nothing after held report");
    endtask

    initial begin
        rst = 1'b1;
        evt_stb = 0; delta_x = 0; delta_y = 0;
        btn_left = 0; btn_mid = 0; btn_right = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latency();
        t_buttons();
        t_motion();
        t_stall();
        t_queued();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule